// File: doc/BRIEF.md
# Indexed Colour Palette Lookup with Byte-Lane Register Port

This block turns an 8-bit pixel index into a 24-bit RGB colour through a 256-entry lookup table. A host reaches it through four word-wide registers on a 32-bit bus. Only the most significant byte of each bus word carries data. The host first loads a shared pointer through the address register. It then streams colour components through the colour-map port in red, green, blue order. A small modulo-3 counter tracks which component comes next. After the blue component the pointer advances by itself, so a whole palette can be loaded with one address write and a run of data writes.

The same pointer also selects a handful of indirect control registers behind the control port. Slot 4 is a pixel read mask. Slots 5 to 7 are plain 8-bit storage; slot 6 holds the overlay setting, and initialisation software writes 0x73 there. On the video side the block takes one pixel index per clock. It ANDs the index with the read mask and returns the selected entry as RGB on the following clock.

Top module: `clut_ramdac`

## Requirements
- R1: After reset the pointer is 0 and the component counter is at red. Every palette entry is 0, the read mask (slot 4) is 0xFF, slots 5 to 7 are 0, and `pixRgb` is 0.
- R2: A write uses only `busWdata[31:24]`; bits 23:0 have no effect. A read returns its byte in `busRdata[31:24]` with bits 23:0 zero.
- R3: `busReg` selects 0 = address, 1 = colour map, 2 = control, 3 = cursor. A write to the cursor register changes no state, and a read of it returns 0.
- R4: Three colour-map writes store red, green and blue. The entry changes only when the blue write commits all three at once; a partial sequence leaves the lookup output unchanged.
- R5: A write to the address register loads the pointer and returns the component counter to red, which abandons any partial sequence.
- R6: After the third component access the pointer increments by one, wrapping from 255 to 0.
- R7: A control-port write stores its byte in the slot named by the pointer when the pointer is 4 to 7, and is ignored for any other pointer value. A control access moves neither the pointer nor the counter. A control read returns the slot, or 0 when the pointer is outside 4 to 7.
- R8: The video lookup uses `pixIndex` ANDed with the slot-4 read mask.
- R9: `pixRgb` shows, one clock after `pixIndex` is presented, the entry as {red[23:16], green[15:8], blue[7:0]}.
- R10: A colour-map read returns red, green, then blue of the pointed entry, following the same counter and auto-increment as writes.
- R11: A read of the address register returns the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busReg | input | 2 | Register select (0 address, 1 colour map, 2 control, 3 cursor) |
| busWdata | input | 32 | Write word, payload in bits 31:24 |
| busRdata | output | 32 | Read word for the selected register, same cycle, payload in bits 31:24 |
| pixIndex | input | 8 | Pixel index from the video stream |
| pixRgb | output | 24 | Looked-up colour, one clock after the index |

## Verification
A wrong pointer or a counter in the wrong phase cannot be seen right away. It shows up at the next colour-map read, which returns the wrong component, or at the next blue write, which commits to the wrong entry. That entry is then visible on `pixRgb` one clock after a pixel index selects it. A read mask with the wrong value shows on the very next lookup as an aliased entry. The reference model follows the pointer, the counter, the staging bytes and the mask on every clock. It compares `pixRgb` on every clock and `busRdata` on every read, so a divergence is reported within a cycle of the first port that exposes it.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int IDX_W     = 8;
  localparam int COMP_W    = 8;
  localparam int BUS_W     = 32;
  localparam int CTL_SLOTS = 4;
  localparam int CTL_BASE  = 4;

  typedef enum logic [1:0] {
    REG_ADDR   = 2'd0,
    REG_CMAP   = 2'd1,
    REG_CTL    = 2'd2,
    REG_CURSOR = 2'd3
  } bus_reg_e;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;

  typedef struct packed {
    logic [IDX_W-1:0] addr;
    comp_e            comp;
    bus_reg_e         rdReg;
    logic             stageRed;
    logic             stageGreen;
    logic             commit;
    logic             ctlWrite;
  } clut_strobes_t;
endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  bus_reg_e          busReg,
  input  logic [COMP_W-1:0] wrByte,
  output clut_strobes_t     strb
);
  localparam int SLOT_W = $clog2(CTL_SLOTS);

  logic [IDX_W-1:0] addrQ;
  comp_e            compQ;
  logic             wrEn;
  logic             addrLoad;
  logic             cmapAccess;
  logic             ctlInRange;

  assign wrEn       = busValid && busWrite;
  assign addrLoad   = wrEn && (busReg == REG_ADDR);
  assign cmapAccess = busValid && (busReg == REG_CMAP);
  assign ctlInRange = (addrQ[IDX_W-1:SLOT_W] == IDX_W'(CTL_BASE) >> SLOT_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      compQ <= COMP_RED;
    end else if (addrLoad) begin
      addrQ <= wrByte;
      compQ <= COMP_RED;
    end else if (cmapAccess) begin
      unique case (compQ)
        COMP_RED:   compQ <= COMP_GREEN;
        COMP_GREEN: compQ <= COMP_BLUE;
        default: begin
          compQ <= COMP_RED;
          addrQ <= addrQ + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.addr       = addrQ;
    strb.comp       = compQ;
    strb.rdReg      = busReg;
    strb.stageRed   = wrEn && (busReg == REG_CMAP) && (compQ == COMP_RED);
    strb.stageGreen = wrEn && (busReg == REG_CMAP) && (compQ == COMP_GREEN);
    strb.commit     = wrEn && (busReg == REG_CMAP) && (compQ == COMP_BLUE);
    strb.ctlWrite   = wrEn && (busReg == REG_CTL) && ctlInRange;
  end
endmodule

// File: rtl/clut_datapath.sv
module clut_datapath
  import clut_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  clut_strobes_t       strb,
  input  logic [COMP_W-1:0]   wrByte,
  input  logic [IDX_W-1:0]    pixIndex,
  output logic [3*COMP_W-1:0] pixRgb,
  output logic [COMP_W-1:0]   rdByte
);
  localparam int ENTRIES   = 1 << IDX_W;
  localparam int RGB_W     = 3 * COMP_W;
  localparam int SLOT_W    = $clog2(CTL_SLOTS);
  localparam int MASK_SLOT = 0;

  logic [COMP_W-1:0]           stageR;
  logic [COMP_W-1:0]           stageG;
  logic [RGB_W-1:0]            lutMem [ENTRIES];
  logic [CTL_SLOTS*COMP_W-1:0] ctlFlat;
  logic [COMP_W-1:0]           readMask;
  logic [IDX_W-1:0]            maskedIdx;
  logic [RGB_W-1:0]            rdEntry;
  logic [SLOT_W-1:0]           slotSel;
  logic                        slotValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageR <= '0;
      stageG <= '0;
    end else begin
      if (strb.stageRed)   stageR <= wrByte;
      if (strb.stageGreen) stageG <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) lutMem[e] <= '0;
    end else if (strb.commit) begin
      lutMem[strb.addr] <= {stageR, stageG, wrByte};
    end
  end

  assign slotSel   = strb.addr[SLOT_W-1:0];
  assign slotValid = (strb.addr[IDX_W-1:SLOT_W] == IDX_W'(CTL_BASE) >> SLOT_W);

  for (genvar g = 0; g < CTL_SLOTS; g++) begin : gSlot
    localparam logic [COMP_W-1:0] RST_VAL = (g == MASK_SLOT) ? '1 : '0;
    logic [COMP_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        slotQ <= RST_VAL;
      else if (strb.ctlWrite && (slotSel == SLOT_W'(g)))
        slotQ <= wrByte;
    end
    assign ctlFlat[g*COMP_W +: COMP_W] = slotQ;
  end

  assign readMask  = ctlFlat[MASK_SLOT*COMP_W +: COMP_W];
  assign maskedIdx = pixIndex & IDX_W'(readMask);

  always_ff @(posedge clk) begin
    if (!rstN) pixRgb <= '0;
    else       pixRgb <= lutMem[maskedIdx];
  end

  assign rdEntry = lutMem[strb.addr];

  always_comb begin
    rdByte = '0;
    unique case (strb.rdReg)
      REG_ADDR: rdByte = COMP_W'(strb.addr);
      REG_CMAP: begin
        unique case (strb.comp)
          COMP_RED:   rdByte = rdEntry[2*COMP_W +: COMP_W];
          COMP_GREEN: rdByte = rdEntry[COMP_W +: COMP_W];
          default:    rdByte = rdEntry[0 +: COMP_W];
        endcase
      end
      REG_CTL:  rdByte = slotValid ? ctlFlat[slotSel*COMP_W +: COMP_W] : '0;
      default:  rdByte = '0;
    endcase
  end
endmodule

// File: rtl/clut_ramdac.sv
module clut_ramdac
  import clut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busReg,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [IDX_W-1:0]  pixIndex,
  output logic [3*COMP_W-1:0] pixRgb
);
  localparam int LANE_LSB = BUS_W - COMP_W;

  clut_strobes_t     strb;
  logic [COMP_W-1:0] wrByte;
  logic [COMP_W-1:0] rdByte;

  assign wrByte = busWdata[BUS_W-1:LANE_LSB];

  clut_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busReg   (bus_reg_e'(busReg)),
    .wrByte   (wrByte),
    .strb     (strb)
  );

  clut_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrByte   (wrByte),
    .pixIndex (pixIndex),
    .pixRgb   (pixRgb),
    .rdByte   (rdByte)
  );

  assign busRdata = {rdByte, {LANE_LSB{1'b0}}};
endmodule

// File: rtl/clut_ramdac_checker.sv
module clut_ramdac_checker
  import clut_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [1:0]           busReg,
  input logic [BUS_W-1:0]     busWdata,
  input logic [BUS_W-1:0]     busRdata,
  input clut_strobes_t        strb
);
  AST_ADDR_LOAD_RED: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busReg == 2'd0) |=>
      (strb.addr == $past(busWdata[BUS_W-1 -: IDX_W]) && strb.comp == COMP_RED)); // R5

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.addr == '1) |=> (strb.addr == '0)); // R6

  AST_CURSOR_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReg == 2'd3) |=> ($stable(strb.addr) && $stable(strb.comp))); // R3

  AST_CTL_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReg == 2'd2) |=> ($stable(strb.addr) && $stable(strb.comp))); // R7

  AST_ADDR_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busReg == 2'd0) |->
      (busRdata[BUS_W-1 -: IDX_W] == strb.addr)); // R11

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stageRed, strb.stageGreen, strb.commit, strb.ctlWrite})); // R4
endmodule

bind clut_ramdac clut_ramdac_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busReg   (busReg),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .strb     (strb)
);

// File: tb/test_clut_ramdac.sv
`timescale 1ns/1ps
module test_clut_ramdac;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busReg = 2'd0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic [7:0]  pixIndex = 8'h0;
  logic [23:0] pixRgb;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  string pixTag = "R9";

  always #2 clk = ~clk;

  clut_ramdac i_clut_ramdac (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busReg(busReg), .busWdata(busWdata), .busRdata(busRdata),
    .pixIndex(pixIndex), .pixRgb(pixRgb)
  );

  // Behavioural reference model
  int         mAddr;
  int         mComp;
  int         mStR, mStG;
  int         mMask;
  int         mCtl [8];
  int         mLut [256];
  logic [23:0] expPix;

  always @(posedge clk) begin
    if (!rstN) begin
      mAddr = 0; mComp = 0; mStR = 0; mStG = 0; mMask = 255;
      for (int i = 0; i < 8; i++) mCtl[i] = 0;
      mCtl[4] = 255;
      for (int i = 0; i < 256; i++) mLut[i] = 0;
      expPix <= 24'h0;
    end else begin
      expPix <= 24'(mLut[pixIndex & mCtl[4]]);
      if (busValid) begin
        int b;
        b = busWdata[31:24];
        case (busReg)
          2'd0: if (busWrite) begin mAddr = b; mComp = 0; end
          2'd1: begin
            if (busWrite) begin
              if (mComp == 0) mStR = b;
              else if (mComp == 1) mStG = b;
              else mLut[mAddr] = (mStR << 16) | (mStG << 8) | b;
            end
            if (mComp == 2) begin mComp = 0; mAddr = (mAddr + 1) % 256; end
            else mComp = mComp + 1;
          end
          2'd2: if (busWrite && mAddr >= 4 && mAddr <= 7) mCtl[mAddr] = b;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [1:0] r);
    int v;
    case (r)
      2'd0: v = mAddr;
      2'd1: v = (mLut[mAddr] >> (8 * (2 - mComp))) & 255;
      2'd2: v = (mAddr >= 4 && mAddr <= 7) ? mCtl[mAddr] : 0;
      default: v = 0;
    endcase
    return {8'(v), 24'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Lookup output compared on every clock
  always @(negedge clk) begin
    if (rstN && !finished) check(pixTag, {8'h0, pixRgb}, {8'h0, expPix});
  end

  task automatic wr(input logic [1:0] r, input logic [7:0] b, input logic [23:0] junk);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busReg = r; busWdata = {b, junk};
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busWdata = 32'h0;
  endtask

  task automatic rd(input logic [1:0] r, input string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busReg = r; busWdata = 32'h00A5_5A3C;
    #1;
    check(tag, busRdata, expRead(r));
    @(negedge clk);
    busValid = 1'b0; busWdata = 32'h0;
  endtask

  task automatic pix(input logic [7:0] p, input string tag);
    @(negedge clk);
    pixTag = tag; pixIndex = p;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic loadRgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    wr(2'd1, r, 24'h123456);
    wr(2'd1, g, 24'hFFFFFF);
    wr(2'd1, b, 24'h00F00F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pixRgb", {8'h0, pixRgb}, 32'h0);
    rd(2'd0, "R1 R11 pointer");
    check("R1 pointer zero", busRdata, 32'h0);
    rd(2'd1, "R1 entry0 red");
    wr(2'd0, 8'd4, 24'h0);
    rd(2'd2, "R1 mask reset");
    check("R1 mask value", expRead(2'd2), 32'hFF00_0000);
    // R7 control init sequence, R2 junk low bits
    wr(2'd2, 8'hFF, 24'hABCDEF);
    wr(2'd0, 8'd5, 24'h0); wr(2'd2, 8'h00, 24'h777777); rd(2'd2, "R7 slot5");
    wr(2'd0, 8'd6, 24'hFFFFFF); wr(2'd2, 8'h73, 24'h8C8C8C); rd(2'd2, "R7 R2 slot6");
    rd(2'd0, "R7 ptr unmoved");
    wr(2'd0, 8'd7, 24'h0); wr(2'd2, 8'h00, 24'h0); rd(2'd2, "R7 slot7");
    wr(2'd0, 8'd8, 24'h0); wr(2'd2, 8'h55, 24'h0); rd(2'd2, "R7 out of range");
    wr(2'd0, 8'd3, 24'h0); rd(2'd2, "R7 below range");
    // R4 R6 three entries with auto-increment
    wr(2'd0, 8'd10, 24'h0);
    loadRgb(8'h11, 8'h22, 8'h33);
    loadRgb(8'h44, 8'h55, 8'h66);
    loadRgb(8'h77, 8'h88, 8'h99);
    rd(2'd0, "R6 ptr after three");
    pix(8'd10, "R9 entry10");
    pix(8'd11, "R9 entry11");
    pix(8'd12, "R9 entry12");
    // R4 partial sequence leaves entry untouched, R5 address restarts at red
    wr(2'd0, 8'd20, 24'h0);
    wr(2'd1, 8'hAA, 24'h0);
    wr(2'd1, 8'hBB, 24'h0);
    pix(8'd20, "R4 partial");
    wr(2'd0, 8'd21, 24'h0);
    loadRgb(8'hC1, 8'hC2, 8'hC3);
    pix(8'd21, "R5 restart");
    pix(8'd20, "R4 entry20 unchanged");
    // R3 cursor write mid-sequence has no effect
    wr(2'd0, 8'd30, 24'h0);
    wr(2'd1, 8'h01, 24'h0);
    wr(2'd3, 8'hEE, 24'hEEEEEE);
    rd(2'd3, "R3 cursor read");
    wr(2'd1, 8'h02, 24'h0);
    wr(2'd1, 8'h03, 24'h0);
    pix(8'd30, "R3 cursor inert");
    rd(2'd0, "R3 ptr");
    // R6 wrap 255 -> 0
    wr(2'd0, 8'd255, 24'h0);
    loadRgb(8'hF1, 8'hF2, 8'hF3);
    rd(2'd0, "R6 wrap");
    pix(8'd255, "R6 entry255");
    // R10 readback order and increment
    wr(2'd0, 8'd10, 24'h0);
    for (int k = 0; k < 6; k++) rd(2'd1, "R10 readback");
    rd(2'd0, "R10 R11 ptr after reads");
    wr(2'd0, 8'd255, 24'h0);
    for (int k = 0; k < 4; k++) rd(2'd1, "R10 read wrap");
    // R8 mask
    wr(2'd0, 8'd4, 24'h0);
    wr(2'd2, 8'h0F, 24'h0);
    pix(8'h1A, "R8 masked 1A");
    pix(8'hFC, "R8 masked FC");
    wr(2'd2, 8'h00, 24'h0);
    pix(8'h15, "R8 mask zero");
    wr(2'd2, 8'hFF, 24'h0);
    pix(8'h15, "R8 mask full");
    // R9 sweep with index changing each clock
    @(negedge clk);
    pixTag = "R9 sweep";
    for (int k = 0; k < 40; k++) begin
      pixIndex = 8'((k * 37) % 256);
      @(negedge clk);
    end
    pix(8'd0, "R9 end");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule